// File: doc/BRIEF.md
# Reset Sequencer with Strap Capture

This block turns an active-low board reset and a watchdog reset request into a clean internal reset for a processor subsystem. The board reset takes effect at once, with no clock needed, and its release passes through a synchroniser chain before the internal reset lifts. A counter then holds back the processor's first instruction fetch for a fixed number of master-clock edges, counted from the release of the board reset.

Two configuration straps are read only while the board reset is held. The first selects the width of the boot memory and the second selects a mode in which every output driver of the chip is turned off. A strap counts as driven low only if it stays low over a whole window of consecutive clock edges that ends just as the board reset lifts. Any disturbance in that window selects the high default. A watchdog reset runs the same release and fetch-delay sequence but leaves the captured straps untouched. A cause flag tells software, after release, which of the two sources caused the last reset.

Top module: `rstseq_top`

## Requirements
- R1: While rst_ni is low, sys_rst_no, fetch_en_o and cause_wdog_o are 0, and they take these values as soon as rst_ni falls, with no clock edge needed.
- R2: With the default two synchroniser stages, sys_rst_no stays 0 through the second rising clock edge after rst_ni goes high and becomes 1 at the third.
- R3: fetch_en_o stays 0 until the FETCH_DELAY-th rising edge after rst_ni goes high (80th by default) and becomes 1 at that edge. It is never 1 while sys_rst_no is 0.
- R4: boot_narrow_o is 0 (16-bit boot memory) only if boot_strap_i was 0 at each of the STRAP_WIN (10) rising edges ending with the first edge after rst_ni rises. Otherwise it is 1 (8-bit boot memory on the first chip select).
- R5: hiz_mode_o is 1 (all output drivers off) only if tri_strap_i was 0 at each of the STRAP_WIN edges of that same window. Otherwise it is 0 (normal operation).
- R6: When wdog_req_i is 1 at a rising edge after the pin release has passed the synchroniser, sys_rst_no and fetch_en_o are 0 after that edge. sys_rst_no returns to 1 at the first edge where wdog_req_i is 0. fetch_en_o returns to 1 at FETCH_DELAY-3 (77) edges after that edge.
- R7: A watchdog reset leaves boot_narrow_o and hiz_mode_o unchanged, whatever the strap inputs do before, during or after it.
- R8: cause_wdog_o is 0 after a pin reset. It becomes 1 after a watchdog reset and keeps that value until the next pin reset.
- R9: A watchdog request raised while rst_ni is low is not recorded: the pin reset wins and cause_wdog_o reads 0 after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Board reset pin, active low, asynchronous assert |
| wdog_req_i | input | 1 | Watchdog reset request, synchronous, active high |
| boot_strap_i | input | 1 | Boot-width strap (1 = 8-bit, 0 = 16-bit) |
| tri_strap_i | input | 1 | Driver-disable strap (0 = disable all outputs) |
| sys_rst_no | output | 1 | Internal system reset, active low |
| fetch_en_o | output | 1 | Processor fetch enable |
| boot_narrow_o | output | 1 | Captured boot width, 1 = 8-bit |
| hiz_mode_o | output | 1 | Captured driver-disable mode, 1 = outputs off |
| cause_wdog_o | output | 1 | Last reset cause, 1 = watchdog, 0 = pin |

## Verification
The bench places a one-cycle strap glitch at every position in and just outside the capture window. This separates a design that samples a single edge, or a window shifted by one edge, from one that needs the whole window to agree. It counts edges exactly from the pin release to the lifting of the internal reset and to the fetch enable, so a missing synchroniser stage or an off-by-one in the delay counter shows up as a wrong value on a specific edge. Watchdog pulses of several lengths, with the straps flipped at the same time, expose a design that resamples straps on a watchdog reset or forgets the reset cause. A watchdog request held during a pin reset exposes a priority inversion.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  typedef enum logic {
    CAUSE_PIN  = 1'b0,
    CAUSE_WDOG = 1'b1
  } cause_e;
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic first_o,
  output logic rel_o
);
  logic [STAGES:0] chain;
  assign chain[0] = 1'b1;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain[i+1] <= 1'b0;
      else         chain[i+1] <= chain[i];
    end
  end

  assign first_o = chain[1];
  assign rel_o   = chain[STAGES];
endmodule

// File: rtl/rstseq_strap.sv
module rstseq_strap #(
  parameter int   WIN     = 10,
  parameter logic DEFAULT = 1'b1
) (
  input  logic clk_i,
  input  logic capture_i,
  input  logic strap_i,
  output logic strap_o
);
  // history is free-running; held value must survive non-pin resets, so no reset here
  logic [WIN-2:0] hist_q;
  logic [WIN-1:0] win;
  logic           held_q;
  logic           steady_alt;

  assign win        = {hist_q, strap_i};
  assign steady_alt = (win == {WIN{~DEFAULT}});

  always_ff @(posedge clk_i) begin
    hist_q <= win[WIN-2:0];
  end

  always_ff @(posedge clk_i) begin
    if (capture_i) held_q <= steady_alt ? ~DEFAULT : DEFAULT;
  end

  assign strap_o = held_q;
endmodule

// File: rtl/rstseq_delay.sv
module rstseq_delay #(
  parameter int COUNT_END = 78
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic done_o
);
  localparam int CntW = $clog2(COUNT_END + 1);

  logic [CntW-1:0] cnt_q;

  assign done_o = (cnt_q == CntW'(COUNT_END));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int FETCH_DELAY = 80,
  parameter int STRAP_WIN   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wdog_req_i,
  input  logic boot_strap_i,
  input  logic tri_strap_i,
  output logic sys_rst_no,
  output logic fetch_en_o,
  output logic boot_narrow_o,
  output logic hiz_mode_o,
  output logic cause_wdog_o
);
  localparam int NumStraps = 2;
  localparam int CountEnd  = FETCH_DELAY - SYNC_STAGES;

  logic pin_first, pin_rel, hold_seq, delay_done;
  logic sys_rst_q;
  cause_e cause_q;
  logic [NumStraps-1:0] strap_raw, strap_held;

  rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .first_o(pin_first),
    .rel_o  (pin_rel)
  );

  // capture runs until the first synchroniser stage has seen the release
  assign strap_raw = {tri_strap_i, boot_strap_i};

  for (genvar s = 0; s < NumStraps; s++) begin : g_strap
    rstseq_strap #(.WIN(STRAP_WIN), .DEFAULT(1'b1)) u_strap (
      .clk_i    (clk_i),
      .capture_i(~pin_first),
      .strap_i  (strap_raw[s]),
      .strap_o  (strap_held[s])
    );
  end

  assign hold_seq = ~pin_rel | wdog_req_i;

  rstseq_delay #(.COUNT_END(CountEnd)) u_delay (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(hold_seq),
    .done_o (delay_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sys_rst_q <= 1'b0;
    else         sys_rst_q <= ~hold_seq;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cause_q <= CAUSE_PIN;
    else if (pin_rel && wdog_req_i) cause_q <= CAUSE_WDOG;
  end

  assign sys_rst_no    = sys_rst_q;
  assign fetch_en_o    = delay_done & sys_rst_q;
  assign boot_narrow_o = strap_held[0];
  assign hiz_mode_o    = ~strap_held[1];
  assign cause_wdog_o  = (cause_q == CAUSE_WDOG);
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wdog_req_i,
  input logic sys_rst_no,
  input logic fetch_en_o,
  input logic boot_narrow_o,
  input logic hiz_mode_o,
  input logic cause_wdog_o
);
  AST_FETCH_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_en_o |-> sys_rst_no); // R3

  AST_FETCH_AFTER_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fetch_en_o) |-> $past(sys_rst_no)); // R3

  AST_RELEASE_BEFORE_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_no) |-> !fetch_en_o); // R3

  AST_WDOG_HOLDS_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_req_i |=> (!sys_rst_no && !fetch_en_o)); // R6

  AST_STRAPS_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_no |=> ($stable(boot_narrow_o) && $stable(hiz_mode_o))); // R7

  AST_WDOG_CAUSE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdog_req_i && sys_rst_no) |=> cause_wdog_o); // R8

  AST_CAUSE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_wdog_o |=> cause_wdog_o); // R8
endmodule

bind rstseq_top rstseq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wdog_req_i   (wdog_req_i),
  .sys_rst_no   (sys_rst_no),
  .fetch_en_o   (fetch_en_o),
  .boot_narrow_o(boot_narrow_o),
  .hiz_mode_o   (hiz_mode_o),
  .cause_wdog_o (cause_wdog_o)
);

// File: tb/rstseq_top_test.sv
`timescale 1ns/1ps
module rstseq_top_test;
  localparam int FETCH_DELAY = 80;
  localparam int STRAP_WIN   = 10;
  localparam int SYNC_STAGES = 2;
  localparam int PRE         = STRAP_WIN + 3;
  localparam int WD_GAP      = FETCH_DELAY - SYNC_STAGES - 1;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wdog_req_i = 1'b0;
  logic boot_strap_i = 1'b1;
  logic tri_strap_i = 1'b1;
  logic sys_rst_no, fetch_en_o, boot_narrow_o, hiz_mode_o, cause_wdog_o;

  int checks = 0;
  int errors = 0;
  bit exp_boot, exp_hiz;

  always #4 clk_i = ~clk_i;

  rstseq_top #(
    .FETCH_DELAY(FETCH_DELAY),
    .STRAP_WIN  (STRAP_WIN),
    .SYNC_STAGES(SYNC_STAGES)
  ) uut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wdog_req_i   (wdog_req_i),
    .boot_strap_i (boot_strap_i),
    .tri_strap_i  (tri_strap_i),
    .sys_rst_no   (sys_rst_no),
    .fetch_en_o   (fetch_en_o),
    .boot_narrow_o(boot_narrow_o),
    .hiz_mode_o   (hiz_mode_o),
    .cause_wdog_o (cause_wdog_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic eq(input string req, input string what, input int act, input int exp);
    check(act == exp, req, what, act, exp);
  endtask

  // strap reads low only if low at every edge of the window and no glitch inside it
  function automatic bit exp_strap(input bit v, input int gpos);
    return (v == 1'b0 && !(gpos >= 0 && gpos < STRAP_WIN)) ? 1'b0 : 1'b1;
  endfunction

  // gpos: edge index before the first post-release edge holding the flipped value, -1 none
  task automatic pin_cycle(input bit boot_v, input bit tri_v, input int gb, input int gt,
                           input bit wd_during);
    bit bad_order = 1'b0;
    @(negedge clk_i);
    #2 rst_ni = 1'b0;
    #1;
    eq("R1", "sys_rst_no async", int'(sys_rst_no), 0);
    eq("R1", "fetch_en_o async", int'(fetch_en_o), 0);
    eq("R1", "cause_wdog_o async", int'(cause_wdog_o), 0);
    for (int i = PRE; i >= 0; i--) begin
      @(negedge clk_i);
      boot_strap_i = (i == gb) ? ~boot_v : boot_v;
      tri_strap_i  = (i == gt) ? ~tri_v  : tri_v;
      if (wd_during) wdog_req_i = (i > 2);
      if (i == 0) rst_ni = 1'b1;
    end
    exp_boot = exp_strap(boot_v, gb);
    exp_hiz  = ~exp_strap(tri_v, gt);
    for (int n = 1; n <= FETCH_DELAY; n++) begin
      @(negedge clk_i);
      if (fetch_en_o && !sys_rst_no) bad_order = 1'b1;
      if (n == 1) begin
        eq("R4", "boot_narrow_o", int'(boot_narrow_o), int'(exp_boot));
        eq("R5", "hiz_mode_o", int'(hiz_mode_o), int'(exp_hiz));
        boot_strap_i = 1'($urandom);
        tri_strap_i  = 1'($urandom);
      end
      if (n == SYNC_STAGES)     eq("R2", "sys_rst_no early", int'(sys_rst_no), 0);
      if (n == SYNC_STAGES + 1) eq("R2", "sys_rst_no release", int'(sys_rst_no), 1);
      if (n == FETCH_DELAY - 1) eq("R3", "fetch_en_o early", int'(fetch_en_o), 0);
      if (n == FETCH_DELAY)     eq("R3", "fetch_en_o on time", int'(fetch_en_o), 1);
    end
    eq("R3", "fetch with reset low", int'(bad_order), 0);
    eq("R4", "boot_narrow_o after straps moved", int'(boot_narrow_o), int'(exp_boot));
    if (wd_during) eq("R9", "cause after overlapped request", int'(cause_wdog_o), 0);
    else           eq("R8", "cause after pin reset", int'(cause_wdog_o), 0);
  endtask

  task automatic wdog_cycle(input int len);
    @(negedge clk_i);
    wdog_req_i   = 1'b1;
    boot_strap_i = ~exp_boot;
    tri_strap_i  = exp_hiz;
    for (int k = 0; k < len; k++) begin
      @(negedge clk_i);
      eq("R6", "sys_rst_no during watchdog", int'(sys_rst_no), 0);
      eq("R6", "fetch_en_o during watchdog", int'(fetch_en_o), 0);
      boot_strap_i = 1'($urandom);
      tri_strap_i  = 1'($urandom);
    end
    wdog_req_i = 1'b0;
    for (int n = 1; n <= WD_GAP + 1; n++) begin
      @(negedge clk_i);
      if (n == 1) begin
        eq("R6", "sys_rst_no after watchdog", int'(sys_rst_no), 1);
        eq("R8", "cause after watchdog", int'(cause_wdog_o), 1);
      end
      if (n == WD_GAP)     eq("R6", "fetch_en_o early", int'(fetch_en_o), 0);
      if (n == WD_GAP + 1) eq("R6", "fetch_en_o on time", int'(fetch_en_o), 1);
    end
    eq("R7", "boot_narrow_o kept", int'(boot_narrow_o), int'(exp_boot));
    eq("R7", "hiz_mode_o kept", int'(hiz_mode_o), int'(exp_hiz));
    repeat (3) @(negedge clk_i);
    eq("R8", "cause sticky", int'(cause_wdog_o), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL timeout: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #5;
    eq("R1", "reset sys_rst_no", int'(sys_rst_no), 0);
    eq("R1", "reset fetch_en_o", int'(fetch_en_o), 0);
    eq("R1", "reset cause_wdog_o", int'(cause_wdog_o), 0);

    // directed: clean lows, glitch at window edges
    pin_cycle(1'b0, 1'b0, -1, -1, 1'b0);
    pin_cycle(1'b0, 1'b0, STRAP_WIN - 1, STRAP_WIN, 1'b0);
    pin_cycle(1'b0, 1'b0, STRAP_WIN, 0, 1'b0);
    pin_cycle(1'b1, 1'b1, -1, -1, 1'b0);
    wdog_cycle(1);
    pin_cycle(1'b0, 1'b1, -1, -1, 1'b1);
    wdog_cycle(4);

    for (int it = 0; it < 30; it++) begin
      bit bv = 1'($urandom);
      bit tv = 1'($urandom);
      int gb = int'($urandom_range(0, STRAP_WIN + 3)) - 1;
      int gt = int'($urandom_range(0, STRAP_WIN + 3)) - 1;
      pin_cycle(bv, tv, gb, gt, 1'($urandom));
      if ($urandom_range(0, 1) == 1) wdog_cycle(int'($urandom_range(1, 6)));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule